// File: doc/BRIEF.md
# Stereo Serial Audio Frame Transmitter

This block turns a stream of 32-bit parallel words into a two-slot serial audio frame. It produces its own word-select line and a serial data line, and both move one bit per pulse of an external bit-clock enable. While word select is low the left slot goes out, and while it is high the right slot goes out. Every slot is a fixed number of bit periods long and carries one sample, most significant bit first, together with padding bits that fill the rest of the slot.

Software-visible settings arrive as plain inputs and are held steady while the transmitter runs:
- the sample length,
- the slot length,
- whether data lags word select by one bit,
- whether padding leads or trails the data,
- the padding level,
- how samples are packed in the parallel word,
- a mute control.

Words arrive over a valid/ready input. When no word is waiting at a load point, the previous word is reused and a sticky flag records the underflow. A setting in which the sample does not fit the slot raises an error output and keeps the transmitter idle.

Top module: `stereo_frame_tx`

## Requirements
- R1: Sample length code `cfg_dlen` decodes 0..5 to 8, 16, 18, 20, 22 and 24 bits, and codes 6 and 7 are invalid. Slot length code `cfg_slen` decodes 0..3 to 8, 16, 24 and 32 bits. `cfg_err` is 1 whenever the sample code is invalid or the sample is longer than the slot. While `cfg_err` is 1, the block stays idle: `ws` and `sd` stay 0 and `s_ready` stays 0.
- R2: While running, each `bclk_en` pulse advances one bit position, and the outputs update on the clock edge that samples the pulse. The first pulse after enable starts the left slot. `ws` is 0 for S bit positions and then 1 for S positions, where S is the slot length. `ws` changes only on a pulse.
- R3: With `cfg_nodelay`=0, the first bit of a slot's sequence appears one bit position after the `ws` change. With `cfg_nodelay`=1, it appears in the same position as the change. In the delayed case, the very first bit after enable is the last bit of a right slot built from an all-zero word.
- R4: Samples go out MSB first. Each slot holds S−D padding bits, where D is the sample length. With `cfg_pad_lead`=0, the data comes first and the padding follows. With `cfg_pad_lead`=1, the padding comes first and the data follows.
- R5: Every padding bit equals `cfg_pad_one`.
- R6: For 8-bit samples, one word carries a left and a right sample in bits [7:0] and [15:8]. For 16-bit samples, it carries them in [15:0] and [31:16]. With `cfg_pack_hi`=0 the lower field is the left sample, and with `cfg_pack_hi`=1 the upper field is the left sample. One word is taken per frame, at the start of the left slot.
- R7: For 18-, 20-, 22- and 24-bit samples, one word is taken per slot. With `cfg_pack_hi`=0 the sample is taken from bits [31:32−D], and with `cfg_pack_hi`=1 it is taken from bits [D−1:0].
- R8: While `cfg_mute`=1, `sd` is 0 in every position, and word select and word consumption continue unchanged.
- R9: `s_ready` is 1 only during a `bclk_en` pulse that starts a slot needing a word. If `s_valid` is 0 at that point, the last word taken (all zero if none) is sent again, and `underflow` becomes 1 and stays 1 until reset.
- R10: Reset clears `ws`, `sd` and `underflow`. With `tx_en`=0, `ws` and `sd` are 0, `s_ready` is 0, and the next enable starts a fresh frame from an all-zero held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| bclk_en | input | 1 | One-cycle pulse per serial bit period |
| cfg_dlen | input | 3 | Sample length code |
| cfg_slen | input | 2 | Slot length code |
| cfg_nodelay | input | 1 | 1: data aligned with word select; 0: one-bit lag |
| cfg_pad_lead | input | 1 | 1: padding before data in a slot |
| cfg_pad_one | input | 1 | Padding bit level |
| cfg_pack_hi | input | 1 | Upper-field-first / right-justified packing |
| cfg_mute | input | 1 | Force serial data low |
| s_valid | input | 1 | Input word valid |
| s_data | input | 32 | Input parallel word |
| s_ready | output | 1 | Word accepted this cycle when valid |
| ws | output | 1 | Word select, 0 left / 1 right |
| sd | output | 1 | Serial data |
| underflow | output | 1 | Sticky: a load point found no word |
| cfg_err | output | 1 | Sample/slot setting invalid |

## Verification
Some properties are checked on every cycle:
- word select moves only on a bit pulse,
- both lines stay low whenever the block is idle,
- mute forces data low,
- the underflow flag never clears,
- a starved load leaves the held word unchanged,
- `s_ready` never rises outside a bit pulse or under a bad setting.

Other behaviour can only be shown by the bench's scenarios, which compare whole frames against a model written from the requirements: the bit order inside each slot under the delay, padding-position and padding-level choices, which field of the word feeds each slot under both packing choices, and the repeated word after starvation.

// File: rtl/tx_pkg.sv
package tx_pkg;

    localparam int WORD_W   = 32;
    localparam int MAX_SLOT = 32;
    localparam int LEN_W    = $clog2(MAX_SLOT) + 1;
    localparam int POS_W    = LEN_W + 1;
    localparam int SAMP_W   = 24;

    typedef enum logic [1:0] {
        PK_BYTE = 2'd0,
        PK_HALF = 2'd1,
        PK_LONG = 2'd2,
        PK_BAD  = 2'd3
    } pack_e;

    typedef struct packed {
        logic [LEN_W-1:0] dlen;
        logic [LEN_W-1:0] slen;
        pack_e            kind;
        logic             nodelay;
        logic             pad_lead;
        logic             pad_one;
        logic             pack_hi;
        logic             mute;
    } tx_cfg_t;

    function automatic logic [LEN_W-1:0] data_len(input logic [2:0] code);
        case (code)
            3'd0:    return LEN_W'(8);
            3'd1:    return LEN_W'(16);
            3'd2:    return LEN_W'(18);
            3'd3:    return LEN_W'(20);
            3'd4:    return LEN_W'(22);
            3'd5:    return LEN_W'(24);
            default: return '0;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] slot_len(input logic [1:0] code);
        case (code)
            2'd0:    return LEN_W'(8);
            2'd1:    return LEN_W'(16);
            2'd2:    return LEN_W'(24);
            default: return LEN_W'(32);
        endcase
    endfunction

    function automatic pack_e pack_kind(input logic [2:0] code);
        case (code)
            3'd0:                   return PK_BYTE;
            3'd1:                   return PK_HALF;
            3'd2, 3'd3, 3'd4, 3'd5: return PK_LONG;
            default:                return PK_BAD;
        endcase
    endfunction

    // Selects the sample for one slot out of a parallel word, right-aligned.
    function automatic logic [SAMP_W-1:0] pick_sample(
        input logic [WORD_W-1:0] word,
        input logic              right_slot,
        input pack_e             kind,
        input logic              pack_hi,
        input logic [LEN_W-1:0]  dlen
    );
        logic              upper;
        logic [WORD_W-1:0] mask;
        upper = right_slot ^ pack_hi;
        mask  = (WORD_W'(1) << dlen) - WORD_W'(1);
        case (kind)
            PK_BYTE: return upper ? SAMP_W'(word[15:8])  : SAMP_W'(word[7:0]);
            PK_HALF: return upper ? SAMP_W'(word[31:16]) : SAMP_W'(word[15:0]);
            PK_LONG: return pack_hi ? SAMP_W'(word & mask)
                                    : SAMP_W'(word >> (WORD_W - int'(dlen)));
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/tx_frame_ctr.sv
module tx_frame_ctr
    import tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] slen,
    input  logic             nodelay,
    output logic             step,
    output logic             ws_next,
    output logic             dslot,
    output logic [LEN_W-1:0] dbit
);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_n;
    logic [POS_W-1:0] last;
    logic [POS_W-1:0] dpos;
    logic [POS_W-1:0] slen_w;

    assign slen_w = POS_W'(slen);
    assign last   = (slen_w << 1) - POS_W'(1);
    assign step   = run && tick;

    always_comb begin
        pos_n = (pos >= last) ? '0 : pos + POS_W'(1);
        if (nodelay) begin
            dpos = pos_n;
        end else begin
            dpos = (pos_n == '0) ? last : pos_n - POS_W'(1);
        end
        ws_next = (pos_n >= slen_w);
        dslot   = (dpos >= slen_w);
        dbit    = dslot ? LEN_W'(dpos - slen_w) : LEN_W'(dpos);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos <= last;
        end else if (step) begin
            pos <= pos_n;
        end
    end

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        run |-> (pos <= last)); // R2

    AST_POS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        run && !tick |=> $stable(pos)); // R2

endmodule

// File: rtl/tx_word_hold.sv
module tx_word_hold
    import tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              step,
    input  logic              dslot,
    input  logic [LEN_W-1:0]  dbit,
    input  pack_e             kind,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    output logic [WORD_W-1:0] word_eff,
    output logic              underflow
);

    logic [WORD_W-1:0] held;
    logic              load;
    logic              take;
    logic              starve;

    // A long sample needs a word per slot; packed short samples one per frame.
    assign load     = step && (dbit == '0) && ((kind == PK_LONG) || !dslot);
    assign take     = load && s_valid;
    assign starve   = load && !s_valid;
    assign s_ready  = load;
    assign word_eff = take ? s_data : held;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            held <= '0;
        end else if (take) begin
            held <= s_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            underflow <= 1'b0;
        end else if (starve) begin
            underflow <= 1'b1;
        end
    end

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow); // R9

    AST_STARVE_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
        starve |=> $stable(held)); // R9

    AST_READY_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> step); // R9

endmodule

// File: rtl/tx_slot_bit.sv
module tx_slot_bit
    import tx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              dslot,
    input  logic [LEN_W-1:0]  dbit,
    input  tx_cfg_t           cfg,
    output logic              bit_out
);

    logic [SAMP_W-1:0] sample;
    logic [LEN_W-1:0]  pad_cnt;
    logic [LEN_W-1:0]  j;
    logic [LEN_W-1:0]  shift;
    logic              in_data;

    always_comb begin
        sample  = pick_sample(word, dslot, cfg.kind, cfg.pack_hi, cfg.dlen);
        pad_cnt = cfg.slen - cfg.dlen;
        if (cfg.pad_lead) begin
            in_data = (dbit >= pad_cnt);
            j       = dbit - pad_cnt;
        end else begin
            in_data = (dbit < cfg.dlen);
            j       = dbit;
        end
        shift = cfg.dlen - LEN_W'(1) - j;
        if (cfg.mute) begin
            bit_out = 1'b0;
        end else if (in_data) begin
            bit_out = sample[shift[$clog2(SAMP_W)-1:0]];
        end else begin
            bit_out = cfg.pad_one;
        end
    end

endmodule

// File: rtl/stereo_frame_tx.sv
module stereo_frame_tx
    import tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_en,
    input  logic        bclk_en,
    input  logic [2:0]  cfg_dlen,
    input  logic [1:0]  cfg_slen,
    input  logic        cfg_nodelay,
    input  logic        cfg_pad_lead,
    input  logic        cfg_pad_one,
    input  logic        cfg_pack_hi,
    input  logic        cfg_mute,
    input  logic        s_valid,
    input  logic [31:0] s_data,
    output logic        s_ready,
    output logic        ws,
    output logic        sd,
    output logic        underflow,
    output logic        cfg_err
);

    tx_cfg_t           cfg;
    logic              run;
    logic              step;
    logic              ws_next;
    logic              dslot;
    logic [LEN_W-1:0]  dbit;
    logic [WORD_W-1:0] word_eff;
    logic              bit_next;

    always_comb begin
        cfg.dlen     = data_len(cfg_dlen);
        cfg.slen     = slot_len(cfg_slen);
        cfg.kind     = pack_kind(cfg_dlen);
        cfg.nodelay  = cfg_nodelay;
        cfg.pad_lead = cfg_pad_lead;
        cfg.pad_one  = cfg_pad_one;
        cfg.pack_hi  = cfg_pack_hi;
        cfg.mute     = cfg_mute;
    end

    assign cfg_err = (cfg.kind == PK_BAD) || (cfg.dlen > cfg.slen);
    assign run     = tx_en && !cfg_err;

    tx_frame_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (bclk_en),
        .slen    (cfg.slen),
        .nodelay (cfg.nodelay),
        .step    (step),
        .ws_next (ws_next),
        .dslot   (dslot),
        .dbit    (dbit)
    );

    tx_word_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .step      (step),
        .dslot     (dslot),
        .dbit      (dbit),
        .kind      (cfg.kind),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .word_eff  (word_eff),
        .underflow (underflow)
    );

    tx_slot_bit u_bit (
        .word    (word_eff),
        .dslot   (dslot),
        .dbit    (dbit),
        .cfg     (cfg),
        .bit_out (bit_next)
    );

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ws <= 1'b0;
            sd <= 1'b0;
        end else if (step) begin
            ws <= ws_next;
            sd <= bit_next;
        end
    end

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!ws && !sd)); // R10

    AST_WS_ON_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
        run && !bclk_en |=> $stable(ws)); // R2

    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        run && cfg_mute && bclk_en |=> !sd); // R8

    AST_BAD_CFG_NO_READY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !s_ready); // R1

endmodule

// File: tb/stereo_frame_tx_tb.sv
module stereo_frame_tx_tb;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [2:0] dwl;
        logic [1:0] swl;
        logic       nd;
        logic       lead;
        logic       one;
        logic       hi;
        logic       mute;
        logic [7:0] avail;
    } vec_t;

    localparam int NV = 9;
    // dwl swl nd lead one hi mute avail
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255}, // R6 R3 16/16 delayed
        '{3'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd255}, // R6 R4 R5 8/16 upper first
        '{3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255}, // R7 left-justified
        '{3'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd255}, // R7 R4 right-justified pad lead
        '{3'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd255}, // R7 R4 18/24
        '{3'd4, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd255}, // R8 mute
        '{3'd5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},   // R9 long starvation
        '{3'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1},   // R9 short starvation
        '{3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255}  // R2 8/8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        bclk_en = 1'b0;
    logic [2:0]  cfg_dlen = '0;
    logic [1:0]  cfg_slen = '0;
    logic        cfg_nodelay = 1'b0;
    logic        cfg_pad_lead = 1'b0;
    logic        cfg_pad_one = 1'b0;
    logic        cfg_pack_hi = 1'b0;
    logic        cfg_mute = 1'b0;
    logic        s_valid;
    logic [31:0] s_data;
    logic        s_ready;
    logic        ws;
    logic        sd;
    logic        underflow;
    logic        cfg_err;

    int  checks = 0;
    int  fails = 0;
    int  idx = 0;
    int  avail = 0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] wgen(input int k);
        logic [31:0] x;
        x = 32'(k + 1) * 32'h9E37_79B9;
        return x ^ 32'h3C5A_0F96;
    endfunction

    assign s_valid = (idx < avail);
    assign s_data  = wgen(idx);

    always @(posedge clk) begin
        if (rst) idx <= 0;
        else if (s_valid && s_ready) idx <= idx + 1;
    end

    stereo_frame_tx u_dut (
        .clk          (clk),
        .rst          (rst),
        .tx_en        (tx_en),
        .bclk_en      (bclk_en),
        .cfg_dlen     (cfg_dlen),
        .cfg_slen     (cfg_slen),
        .cfg_nodelay  (cfg_nodelay),
        .cfg_pad_lead (cfg_pad_lead),
        .cfg_pad_one  (cfg_pad_one),
        .cfg_pack_hi  (cfg_pack_hi),
        .cfg_mute     (cfg_mute),
        .s_valid      (s_valid),
        .s_data       (s_data),
        .s_ready      (s_ready),
        .ws           (ws),
        .sd           (sd),
        .underflow    (underflow),
        .cfg_err      (cfg_err)
    );

    function automatic int dlen_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 18;
            3'd3: return 20;
            3'd4: return 22;
            default: return 24;
        endcase
    endfunction

    function automatic logic [31:0] word_for(input int k, input int av);
        if (k < 0 || av == 0) return 32'h0;
        if (k >= av) return wgen(av - 1);
        return wgen(k);
    endfunction

    // Expected serial bit after tick n of a run, built from R3..R8.
    function automatic logic exp_bit(input vec_t v, input int n);
        int S, D, g, fr, r, b, k, j, pad;
        logic slot, sel, is_short;
        logic [31:0] w, smp;
        S = 8 * (int'(v.swl) + 1);
        D = dlen_of(v.dwl);
        is_short = (D <= 16);
        g = n - (v.nd ? 0 : 1);
        if (g < 0) begin
            w = 32'h0; slot = 1'b1; b = S - 1;
        end else begin
            fr = g / (2 * S);
            r  = g % (2 * S);
            slot = (r >= S);
            b  = r % S;
            k  = is_short ? fr : 2 * fr + int'(slot);
            w  = word_for(k, int'(v.avail));
        end
        sel = slot ^ v.hi;
        if (D == 16)     smp = sel ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        else if (D == 8) smp = sel ? {24'h0, w[15:8]}  : {24'h0, w[7:0]};
        else             smp = v.hi ? (w & ((32'h1 << D) - 32'h1)) : (w >> (32 - D));
        pad = S - D;
        if (v.mute) return 1'b0;
        if (v.lead) begin
            if (b < pad) return v.one;
            j = b - pad;
        end else begin
            if (b >= D) return v.one;
            j = b;
        end
        return smp[D - 1 - j];
    endfunction

    function automatic int exp_loads(input vec_t v, input int nt);
        int S, D, g, r, cnt;
        cnt = 0;
        S = 8 * (int'(v.swl) + 1);
        D = dlen_of(v.dwl);
        for (int n = 0; n < nt; n++) begin
            g = n - (v.nd ? 0 : 1);
            if (g >= 0) begin
                r = g % (2 * S);
                if ((r % S) == 0 && (D > 16 || r < S)) cnt++;
            end
        end
        return cnt;
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) bclk_en = 1'b1;
        @(negedge clk) bclk_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t v;
        int   S, nt, ld, bad_seen;
        string tag;

        // R10: reset state
        do_reset();
        check("R10", "ws after reset", int'(ws), 0);
        check("R10", "sd after reset", int'(sd), 0);
        check("R10", "underflow after reset", int'(underflow), 0);
        avail = 255;
        cfg_dlen = 3'd1; cfg_slen = 2'd1;
        // R10: disabled block ignores pulses and takes no words
        for (int i = 0; i < 8; i++) begin
            tick();
            check("R10", "ws while disabled", int'(ws), 0);
        end
        check("R10", "words taken while disabled", idx, 0);

        // R1: configuration error handling
        cfg_dlen = 3'd5; cfg_slen = 2'd1;
        @(negedge clk);
        check("R1", "cfg_err 24 in 16", int'(cfg_err), 1);
        tx_en = 1'b1;
        bad_seen = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (ws || sd) bad_seen++;
        end
        check("R1", "lines active under bad cfg", bad_seen, 0);
        check("R1", "words taken under bad cfg", idx, 0);
        cfg_dlen = 3'd6; cfg_slen = 2'd3;
        @(negedge clk);
        check("R1", "cfg_err code 6", int'(cfg_err), 1);
        cfg_dlen = 3'd5;
        @(negedge clk);
        check("R1", "cfg_err 24 in 32", int'(cfg_err), 0);
        tx_en = 1'b0;

        // Table walk: R2..R9
        for (int vi = 0; vi < NV; vi++) begin
            v = VECS[vi];
            cfg_dlen = v.dwl; cfg_slen = v.swl; cfg_nodelay = v.nd;
            cfg_pad_lead = v.lead; cfg_pad_one = v.one;
            cfg_pack_hi = v.hi; cfg_mute = v.mute;
            avail = int'(v.avail);
            do_reset();
            tx_en = 1'b1;
            S  = 8 * (int'(v.swl) + 1);
            nt = 6 * S;
            if (v.mute) tag = "R8";
            else if (dlen_of(v.dwl) <= 16) tag = "R6 R3 R4 R5";
            else tag = "R7 R3 R4 R5";
            for (int n = 0; n < nt; n++) begin
                tick();
                check("R2", $sformatf("ws vec %0d tick %0d", vi, n),
                      int'(ws), int'((n % (2 * S)) >= S));
                check(tag, $sformatf("sd vec %0d tick %0d", vi, n),
                      int'(sd), int'(exp_bit(v, n)));
            end
            ld = exp_loads(v, nt);
            check("R9", $sformatf("underflow vec %0d", vi), int'(underflow),
                  int'(ld > int'(v.avail)));
            check("R9", $sformatf("words taken vec %0d", vi), idx,
                  (ld < int'(v.avail)) ? ld : int'(v.avail));
            tx_en = 1'b0;
            @(negedge clk);
            check("R10", $sformatf("idle after disable vec %0d", vi),
                  int'(ws) + int'(sd), 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule